// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Date Alarm

This block is a real-time calendar counter that runs from a 32768 Hz enable pulse on the system clock. It holds seconds, minutes, hours, day of month, month, a two-digit year (00 to 99, read as 2000 to 2099) and a day of week. Every field except the day of week is a packed BCD byte. The calendar always works in 24-hour form.

A prescaler counts enabled ticks. When a full second has gone by, every field is stepped at once, with carries rippling through the calendar. One-cycle pulses mark each new second, minute, hour and day. A separate alarm pulse fires when the new time equals a complete alarm date and time. No alarm field can be ignored.

A busy flag covers the last tick period before each step, so software can wait for a quiet window before it accesses the fields. Software sets the time with per-field load strobes that share one data byte. The block advances only while its run input is high.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00, weekday 0. busy and every event output are low.
- R2: The calendar advances by one second on the clock edge that completes TICKS_PER_SEC cycles in which run and tick_en were both high. When run is low or tick_en is low, every field holds.
- R3: Seconds and minutes roll from 59 to 00 and hours from 23 to 00. Each BCD ones digit carries from 9 into its tens digit.
- R4: After the last day of its month, the day returns to 01. April, June, September and November have 30 days. February has 28 days, or 29 when the year value is a multiple of 4 (00 included). All other months have 31 days.
- R5: When the day wraps, month 12 becomes 01 and the year increments. Year 99 becomes 00.
- R6: The weekday counts 0 to 6, wrapping to 0, and advances exactly when the day advances.
- R7: ev_sec is high for one cycle together with each new second value. ev_min is high with it when seconds wrapped, ev_hour when minutes also wrapped, and ev_day when hours also wrapped.
- R8: alarm_hit is high for one cycle together with a new second value when seconds, minutes, hours, day, month and year all equal alarm_time. alarm_time is packed as {year, month, day, hour, minute, second}, with seconds in bits 7:0. If any one of these fields differs, no pulse is produced.
- R9: busy is high while run is high and the prescaler is in its final tick period. It goes low on the edge where the calendar steps.
- R10: ld_sel bit i writes ld_data into one field on the next edge. The bits are: 0 weekday (low 3 bits), 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year. A seconds load restarts the prescaler, so the next step comes a full TICKS_PER_SEC ticks later. A cycle with any load strobe neither advances the prescaler nor steps the calendar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz rate |
| run | input | 1 | High lets the calendar count |
| ld_sel | input | 7 | Per-field load strobes |
| ld_data | input | 8 | BCD data for the loaded field |
| alarm_time | input | 48 | Alarm {year, month, day, hour, minute, second} in BCD |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours 00 to 23, BCD |
| day | output | 8 | Day of month, BCD |
| mon | output | 8 | Month 01 to 12, BCD |
| year | output | 8 | Year 00 to 99, BCD |
| wday | output | 3 | Day of week 0 to 6 |
| ev_sec | output | 1 | New-second pulse |
| ev_min | output | 1 | New-minute pulse |
| ev_hour | output | 1 | New-hour pulse |
| ev_day | output | 1 | New-day pulse |
| alarm_hit | output | 1 | Alarm match pulse |
| busy | output | 1 | Update imminent |

## Verification
A field load shows on the outputs one edge after its strobe. The bench therefore drives strobes at falling edges and reads the field back at the next falling edge. With tick_en held high and a restarted prescaler, the step lands on the TICKS_PER_SEC-th rising edge after run rises. busy is due one edge earlier. The events and alarm_hit appear in the same cycle as the new time and are gone one cycle later. Each check samples at the falling edge that follows the exact rising edge counted for that result.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        run,
  input  logic [6:0]  ld_sel,
  input  logic [7:0]  ld_data,
  input  logic [47:0] alarm_time,
  output logic [7:0]  sec,
  output logic [7:0]  min,
  output logic [7:0]  hour,
  output logic [7:0]  day,
  output logic [7:0]  mon,
  output logic [7:0]  year,
  output logic [2:0]  wday,
  output logic        ev_sec,
  output logic        ev_min,
  output logic        ev_hour,
  output logic        ev_day,
  output logic        alarm_hit,
  output logic        busy
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  function automatic logic [7:0] bcd_inc(input logic [7:0] x);
    return (x[3:0] == 4'd9) ? {x[7:4] + 4'd1, 4'd0} : x + 8'd1;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    case (m)
      8'h02:                      return (r == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  logic [CW-1:0] pre;
  logic          any_ld, advance, step;
  logic          c_min, c_hour, c_day, c_mon, c_year;
  logic [7:0]    n_sec, n_min, n_hour, n_day, n_mon, n_year;
  logic [2:0]    n_wday;

  assign any_ld  = |ld_sel;
  assign advance = run && tick_en && !any_ld;
  assign step    = advance && (pre == LAST);
  assign busy    = run && (pre == LAST);

  assign c_min  = sec == 8'h59;
  assign c_hour = c_min && (min == 8'h59);
  assign c_day  = c_hour && (hour == 8'h23);
  assign c_mon  = c_day && (day == month_len(mon, year));
  assign c_year = c_mon && (mon == 8'h12);

  assign n_sec  = c_min  ? 8'h00 : bcd_inc(sec);
  assign n_min  = c_hour ? 8'h00 : (c_min  ? bcd_inc(min)  : min);
  assign n_hour = c_day  ? 8'h00 : (c_hour ? bcd_inc(hour) : hour);
  assign n_day  = c_mon  ? 8'h01 : (c_day  ? bcd_inc(day)  : day);
  assign n_mon  = c_year ? 8'h01 : (c_mon  ? bcd_inc(mon)  : mon);
  assign n_year = !c_year ? year : ((year == 8'h99) ? 8'h00 : bcd_inc(year));
  assign n_wday = !c_day ? wday : ((wday == 3'd6) ? 3'd0 : wday + 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
    end else if (ld_sel[1]) begin
      pre <= '0;
    end else if (advance) begin
      pre <= (pre == LAST) ? '0 : pre + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00;
      day <= 8'h01; mon <= 8'h01; year <= 8'h00; wday <= 3'd0;
    end else if (any_ld) begin
      if (ld_sel[0]) wday <= ld_data[2:0];
      if (ld_sel[1]) sec  <= ld_data;
      if (ld_sel[2]) min  <= ld_data;
      if (ld_sel[3]) hour <= ld_data;
      if (ld_sel[4]) day  <= ld_data;
      if (ld_sel[5]) mon  <= ld_data;
      if (ld_sel[6]) year <= ld_data;
    end else if (step) begin
      sec <= n_sec; min <= n_min; hour <= n_hour;
      day <= n_day; mon <= n_mon; year <= n_year; wday <= n_wday;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_sec <= 1'b0; ev_min <= 1'b0; ev_hour <= 1'b0; ev_day <= 1'b0;
      alarm_hit <= 1'b0;
    end else begin
      ev_sec    <= step;
      ev_min    <= step && c_min;
      ev_hour   <= step && c_hour;
      ev_day    <= step && c_day;
      alarm_hit <= step && ({n_year, n_mon, n_day, n_hour, n_min, n_sec} == alarm_time);
    end
  end

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && ld_sel == 7'd0) |=> $stable({sec, min, hour, day, mon, year, wday}));

  a_r7_min_implies_sec: assert property (@(posedge clk) disable iff (!rst_n)
    ev_min |-> (ev_sec && sec == 8'h00));

  a_r7_day_at_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    ev_day |-> (ev_hour && hour == 8'h00 && min == 8'h00));

  a_r8_alarm_matches: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> (ev_sec && {year, mon, day, hour, min, sec} == alarm_time));

  a_r9_busy_precedes_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(tick_en) && $past(run) && $past(ld_sel) == 7'd0) |-> ev_sec);

  a_r10_sec_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sel[1] |=> (sec == $past(ld_data) && !ev_sec));
endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  localparam int TPS = 4;
  localparam int NV  = 12;
  // {start 56, expected 56, events {day,hour,min,sec}, alarm enable}
  // time packing: year mon day hour min sec 0w
  localparam logic [119:0] VEC [NV] = '{
    {56'h00010100000000, 56'h00010100000100, 4'b0001, 4'h1},
    {56'h24051012345903, 56'h24051012350003, 4'b0011, 4'h0},
    {56'h24051009595903, 56'h24051010000003, 4'b0111, 4'h0},
    {56'h23043023595906, 56'h23050100000000, 4'b1111, 4'h1},
    {56'h23022823595902, 56'h23030100000003, 4'b1111, 4'h0},
    {56'h24022823595902, 56'h24022900000003, 4'b1111, 4'h0},
    {56'h24022923595903, 56'h24030100000004, 4'b1111, 4'h1},
    {56'h99123123595905, 56'h00010100000006, 4'b1111, 4'h1},
    {56'h00022823595901, 56'h00022900000002, 4'b1111, 4'h0},
    {56'h21013123595904, 56'h21020100000005, 4'b1111, 4'h0},
    {56'h21073023595901, 56'h21073100000002, 4'b1111, 4'h0},
    {56'h21093023595901, 56'h21100100000002, 4'b1111, 4'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, run = 1'b0;
  logic [6:0] ld_sel = '0;
  logic [7:0] ld_data = '0;
  logic [47:0] alarm_time = '0;
  logic [7:0] sec, min, hour, day, mon, year;
  logic [2:0] wday;
  logic ev_sec, ev_min, ev_hour, ev_day, alarm_hit, busy;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
    .ld_sel(ld_sel), .ld_data(ld_data), .alarm_time(alarm_time),
    .sec(sec), .min(min), .hour(hour), .day(day), .mon(mon), .year(year),
    .wday(wday), .ev_sec(ev_sec), .ev_min(ev_min), .ev_hour(ev_hour),
    .ev_day(ev_day), .alarm_hit(alarm_hit), .busy(busy));

  function automatic logic [55:0] now_t();
    return {year, mon, day, hour, min, sec, 5'd0, wday};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_time(input logic [55:0] t);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      ld_sel = 7'(1 << i);
      ld_data = t[8*i +: 8];
    end
    @(negedge clk);
    ld_sel = '0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset time", 64'(now_t()), 64'h00010100000000);
    check("R1 reset flags", 64'({busy, ev_sec, ev_min, ev_hour, ev_day, alarm_hit}), 64'd0);

    // vector table
    tick_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      logic [55:0] st, ex;
      st = VEC[v][119:64];
      ex = VEC[v][63:8];
      alarm_time = (VEC[v][0]) ? ex[55:8] : (ex[55:8] ^ 48'h01_0000_0000_00);
      load_time(st);
      run = 1'b1;
      repeat (TPS - 1) @(posedge clk);
      @(negedge clk);
      check("R9 busy before step", 64'(busy), 64'd1);
      @(posedge clk);
      @(negedge clk);
      run = 1'b0;
      check("R3,R4,R5,R6 next time", 64'(now_t()), 64'(ex));
      check("R7 events", 64'({ev_day, ev_hour, ev_min, ev_sec}), 64'(VEC[v][7:4]));
      check("R8 alarm", 64'(alarm_hit), 64'(VEC[v][0]));
      check("R9 busy cleared", 64'(busy), 64'd0);
      @(negedge clk);
      check("R7 single-cycle pulse", 64'({ev_sec, alarm_hit}), 64'd0);
    end

    // R2: run low freezes
    load_time(56'h24061511223304);
    repeat (12) @(negedge clk);
    check("R2 frozen with run low", 64'(now_t()), 64'h24061511223304);
    // R2: tick_en low freezes
    tick_en = 1'b0; run = 1'b1;
    repeat (12) @(negedge clk);
    check("R2 frozen with tick_en low", 64'(now_t()), 64'h24061511223304);
    check("R9 no busy without ticks", 64'(busy), 64'd0);

    // R10: seconds load restarts prescaler
    tick_en = 1'b1;
    repeat (2) @(negedge clk);
    ld_sel = 7'b0000010; ld_data = 8'h30;
    @(negedge clk);
    ld_sel = '0;
    check("R10 sec loaded", 64'(sec), 64'h30);
    repeat (TPS - 1) @(negedge clk);
    check("R10 no early step", 64'(sec), 64'h30);
    @(negedge clk);
    check("R10 step after full second", 64'({sec, 7'd0, ev_sec}), 64'({8'h31, 8'h01}));
    @(negedge clk);
    check("R7 ev_sec drops", 64'(ev_sec), 64'd0);

    // R10: load cycle does not advance prescaler
    repeat (TPS - 3) @(negedge clk);
    ld_sel = 7'b0000100; ld_data = 8'h45;
    @(negedge clk);
    ld_sel = '0;
    check("R10 min loaded", 64'({min, sec}), 64'h4531);
    @(negedge clk);
    check("R10 held prescaler", 64'(sec), 64'h31);
    @(negedge clk);
    check("R10 step after delay", 64'(sec), 64'h32);
    run = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule